// File: doc/BRIEF.md
# Parallel Add-Subtract Unit with Saturation

This unit takes one pair of signed operands and produces both their sum and their difference in the same cycle, so that code doing butterflies or mid/side splits gets both results from a single issue. It works either on the full 32-bit word or on two independent 16-bit halfword lanes. In either layout, the results can wrap in two's complement or saturate to the signed limits.

Inputs are sampled on a clock edge when `in_valid` is high. The sum word and the difference word appear, registered, one cycle later, together with `out_valid`. Whenever a result is clamped, a sticky flag records it: one flag covers the sum path and the other covers the difference path. The flags stay set until software-side logic pulses `flag_clr`. A clamp in the same cycle as a clear still leaves its flag set, so no saturation event is lost.

Top module: `pasu_top`

## Requirements
- R1: Results on `sum_q`/`diff_q` and `out_valid`=1 appear on the first clock edge after the edge that samples `in_valid`=1; `out_valid` is 0 in a cycle that follows an edge with `in_valid`=0.
- R2: With `lane_mode`=0 and `sat_en`=0, `sum_q` = (opa+opb) mod 2^32 and `diff_q` = (opa-opb) mod 2^32.
- R3: With `lane_mode`=1, bits [15:0] and [31:16] are computed as two independent 16-bit lanes, and no carry or borrow passes from the low lane into the high lane.
- R4: With `lane_mode`=0 and `sat_en`=1, a signed result above 2^31-1 becomes 0x7FFF_FFFF and a signed result below -2^31 becomes 0x8000_0000.
- R5: With `lane_mode`=1 and `sat_en`=1, each lane result that overflows is clamped on its own, to 0x7FFF (positive) or 0x8000 (negative).
- R6: A clamp on the sum path sets `sat_sticky[0]`, and a clamp on the difference path sets `sat_sticky[1]`. Both are visible in the same cycle as the clamped result.
- R7: A set sticky bit stays set until a cycle where `flag_clr`=1. That edge clears it unless a clamp of the same path is sampled on the same edge, in which case the clamp wins.
- R8: When `in_valid`=0, `sum_q` and `diff_q` keep their previous values.
- R9: After reset, `out_valid`, `sum_q`, `diff_q` and `sat_sticky` are all zero.
- R10: With `sat_en`=0, overflow wraps, and it sets no sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| opa | input | 32 | First operand (A) |
| opb | input | 32 | Second operand (B) |
| lane_mode | input | 1 | 0: one 32-bit value, 1: two 16-bit lanes |
| sat_en | input | 1 | 1: saturate on overflow, 0: wrap |
| flag_clr | input | 1 | Clear pulse for the sticky flags |
| out_valid | output | 1 | Registered results valid |
| sum_q | output | 32 | Registered A+B |
| diff_q | output | 32 | Registered A-B |
| sat_sticky | output | 2 | Sticky clamp flags: bit0 sum, bit1 difference |

## Verification
The bench aims at lane isolation: 0xFFFF+1 in the low lane, and 0-1 in the low lane. A design that lets the carry or borrow leak would change the high halfword. It also drives operands that overflow only on the difference path, such as 0x8000_0000-1 and 0x4000_0000-(-2^30). It drives lanes where one lane saturates and the other does not. A design that reuses the addition overflow test for subtraction, or that clamps the whole word, would return wrong limits or raise the wrong flag. Other directed cases cover these faults:
- a flag lost when a clear coincides with a clamp
- a flag that fails to persist
- outputs that change while `in_valid` is low

// File: rtl/pasu_pkg.sv
package pasu_pkg;

  typedef enum logic {
    MODE_WORD = 1'b0,
    MODE_DUAL = 1'b1
  } lane_mode_e;

  // Signed overflow of a+b given operand and result signs.
  function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // Signed overflow of a-b given operand and result signs.
  function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction

endpackage

// File: rtl/pasu_addsub.sv
module pasu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sat,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic         sum_clamp,
  output logic         diff_clamp
);
  import pasu_pkg::*;

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sum_raw, diff_raw, limit;
  logic         sum_ovf, diff_ovf;

  always_comb begin
    sum_raw  = a + b;
    diff_raw = a - b;
    sum_ovf  = add_ovf(a[W-1], b[W-1], sum_raw[W-1]);
    diff_ovf = sub_ovf(a[W-1], b[W-1], diff_raw[W-1]);
    // On either overflow the true result has the sign of a.
    limit      = a[W-1] ? SMIN : SMAX;
    sum_clamp  = sat && sum_ovf;
    diff_clamp = sat && diff_ovf;
    sum        = sum_clamp  ? limit : sum_raw;
    diff       = diff_clamp ? limit : diff_raw;
  end

endmodule

// File: rtl/pasu_core.sv
module pasu_core #(
  parameter int DATA_W = 32,
  parameter int LANES  = 2
) (
  input  logic              mode_dual,
  input  logic              sat,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] diff,
  output logic              sum_clamp,
  output logic              diff_clamp
);
  import pasu_pkg::*;

  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] w_sum, w_diff, l_sum, l_diff;
  logic              w_sc, w_dc;
  logic [LANES-1:0]  l_sc, l_dc;
  lane_mode_e        mode;

  assign mode = lane_mode_e'(mode_dual);

  pasu_addsub #(.W(DATA_W)) u_word (
    .a(a), .b(b), .sat(sat),
    .sum(w_sum), .diff(w_diff),
    .sum_clamp(w_sc), .diff_clamp(w_dc)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pasu_addsub #(.W(LANE_W)) u_lane (
      .a(a[g*LANE_W +: LANE_W]),
      .b(b[g*LANE_W +: LANE_W]),
      .sat(sat),
      .sum(l_sum[g*LANE_W +: LANE_W]),
      .diff(l_diff[g*LANE_W +: LANE_W]),
      .sum_clamp(l_sc[g]),
      .diff_clamp(l_dc[g])
    );
  end

  always_comb begin
    if (mode == MODE_DUAL) begin
      sum        = l_sum;
      diff       = l_diff;
      sum_clamp  = |l_sc;
      diff_clamp = |l_dc;
    end else begin
      sum        = w_sum;
      diff       = w_diff;
      sum_clamp  = w_sc;
      diff_clamp = w_dc;
    end
  end

endmodule

// File: rtl/pasu_sticky.sv
module pasu_sticky #(
  parameter int NFLAGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [NFLAGS-1:0] set,
  output logic [NFLAGS-1:0] flags
);

  // A set on the same edge as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (clr ? '0 : flags) | set;
  end

endmodule

// File: rtl/pasu_top.sv
module pasu_top #(
  parameter int DATA_W = 32,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              lane_mode,
  input  logic              sat_en,
  input  logic              flag_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] sum_q,
  output logic [DATA_W-1:0] diff_q,
  output logic [1:0]        sat_sticky
);

  logic [DATA_W-1:0] sum_d, diff_d;
  logic              sum_clamp, diff_clamp;
  logic              sum_clamp_ev, diff_clamp_ev;

  pasu_core #(.DATA_W(DATA_W), .LANES(LANES)) u_core (
    .mode_dual(lane_mode), .sat(sat_en),
    .a(opa), .b(opb),
    .sum(sum_d), .diff(diff_d),
    .sum_clamp(sum_clamp), .diff_clamp(diff_clamp)
  );

  // Clamp events that actually reach the result registers.
  assign sum_clamp_ev  = in_valid && sum_clamp;
  assign diff_clamp_ev = in_valid && diff_clamp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum_q     <= '0;
      diff_q    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum_q  <= sum_d;
        diff_q <= diff_d;
      end
    end
  end

  pasu_sticky #(.NFLAGS(2)) u_sticky (
    .clk(clk), .rst_n(rst_n), .clr(flag_clr),
    .set({diff_clamp_ev, sum_clamp_ev}),
    .flags(sat_sticky)
  );

endmodule

// File: rtl/pasu_checker.sv
module pasu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              lane_mode,
  input logic              sat_en,
  input logic              flag_clr,
  input logic              out_valid,
  input logic [DATA_W-1:0] sum_q,
  input logic [DATA_W-1:0] diff_q,
  input logic [1:0]        sat_sticky,
  input logic              sum_clamp_ev,
  input logic              diff_clamp_ev
);

  localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_word_clamp_value: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_clamp_ev && !lane_mode) |=> (sum_q == SMAX || sum_q == SMIN));
  a_r4_word_diff_clamp_value: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_clamp_ev && !lane_mode) |=> (diff_q == SMAX || diff_q == SMIN));
  a_r6_sum_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    sum_clamp_ev |=> sat_sticky[0]);
  a_r6_diff_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    diff_clamp_ev |=> sat_sticky[1]);
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((sat_sticky & $past(sat_sticky)) == $past(sat_sticky)));
  a_r7_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !in_valid) |=> (sat_sticky == 2'b00));
  a_r8_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum_q) && $stable(diff_q)));
  a_r10_wrap_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sat_en) |-> (!sum_clamp_ev && !diff_clamp_ev));

endmodule

bind pasu_top pasu_checker #(.DATA_W(DATA_W)) u_pasu_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .lane_mode(lane_mode), .sat_en(sat_en), .flag_clr(flag_clr),
  .out_valid(out_valid), .sum_q(sum_q), .diff_q(diff_q),
  .sat_sticky(sat_sticky),
  .sum_clamp_ev(sum_clamp_ev), .diff_clamp_ev(diff_clamp_ev)
);

// File: tb/tb_pasu_top.sv
`timescale 1ns/1ps
module tb_pasu_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        lane_mode = 1'b0, sat_en = 1'b0, flag_clr = 1'b0;
  logic        out_valid;
  logic [31:0] sum_q, diff_q;
  logic [1:0]  sat_sticky;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pasu_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .opa(opa), .opb(opb), .lane_mode(lane_mode),
    .sat_en(sat_en), .flag_clr(flag_clr),
    .out_valid(out_valid), .sum_q(sum_q), .diff_q(diff_q),
    .sat_sticky(sat_sticky)
  );

  localparam int NV = 11;
  // {lane_mode, sat_en}
  localparam logic [1:0]  T_MS [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b01,
                                        2'b10, 2'b10, 2'b11, 2'b11, 2'b11, 2'b01};
  localparam logic [31:0] T_A  [NV] = '{32'h0000_0005, 32'h7FFF_FFFF, 32'h7FFF_FFFF,
                                        32'h8000_0000, 32'h8000_0000, 32'h0001_FFFF,
                                        32'h0000_0000, 32'h7FFF_8000, 32'h8000_7FFF,
                                        32'h0010_FFF0, 32'h4000_0000};
  localparam logic [31:0] T_B  [NV] = '{32'h0000_0003, 32'h0000_0001, 32'h0000_0001,
                                        32'h0000_0001, 32'h8000_0000, 32'h0001_0001,
                                        32'h0000_0001, 32'h0001_0001, 32'hFFFF_FFFF,
                                        32'h0005_0020, 32'hC000_0000};
  localparam logic [31:0] T_S  [NV] = '{32'h0000_0008, 32'h8000_0000, 32'h7FFF_FFFF,
                                        32'h8000_0001, 32'h8000_0000, 32'h0002_0000,
                                        32'h0000_0001, 32'h7FFF_8001, 32'h8000_7FFE,
                                        32'h0015_0010, 32'h0000_0000};
  localparam logic [31:0] T_D  [NV] = '{32'h0000_0002, 32'h7FFF_FFFE, 32'h7FFF_FFFE,
                                        32'h8000_0000, 32'h0000_0000, 32'h0000_FFFE,
                                        32'h0000_FFFF, 32'h7FFE_8000, 32'h8001_7FFF,
                                        32'h000B_FFD0, 32'h7FFF_FFFF};
  // {diff flag, sum flag}
  localparam logic [1:0]  T_F  [NV] = '{2'b00, 2'b00, 2'b01, 2'b10, 2'b01,
                                        2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 2'b10};
  localparam string       T_R  [NV] = '{"R2", "R2/R10", "R4", "R4", "R4",
                                        "R3", "R3", "R5", "R5", "R3", "R4"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation at a negedge, then sample at the following negedge.
  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic m, input logic s, input logic c);
    @(negedge clk);
    opa = a; opb = b; lane_mode = m; sat_en = s; flag_clr = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic idle(input logic c);
    @(negedge clk);
    flag_clr = c; in_valid = 1'b0;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] hold_s, hold_d;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9 sum_q", sum_q, 32'd0);
    chk("R9 diff_q", diff_q, 32'd0);
    chk("R9 sat_sticky", {30'd0, sat_sticky}, 32'd0);
    rst_n = 1'b1;

    // Table walk; each vector also pulses clear so flags show just its own clamps (R6, R7).
    for (int i = 0; i < NV; i++) begin
      issue(T_A[i], T_B[i], T_MS[i][1], T_MS[i][0], 1'b1);
      chk({T_R[i], " R1 valid"}, {31'd0, out_valid}, 32'd1);
      chk({T_R[i], " sum"}, sum_q, T_S[i]);
      chk({T_R[i], " diff"}, diff_q, T_D[i]);
      chk({T_R[i], " R6 flags"}, {30'd0, sat_sticky}, {30'd0, T_F[i]});
    end

    // R1: valid drops the cycle after in_valid drops
    @(negedge clk);
    chk("R1 valid low", {31'd0, out_valid}, 32'd0);

    // R8: results hold while in_valid is low, even with new operands present
    hold_s = sum_q; hold_d = diff_q;
    @(negedge clk);
    opa = 32'h1234_5678; opb = 32'h1111_1111; lane_mode = 1'b0; sat_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 sum hold", sum_q, hold_s);
    chk("R8 diff hold", diff_q, hold_d);

    // R7: clear alone empties flags (diff flag still set from last vector)
    chk("R7 flag before clear", {30'd0, sat_sticky}, 32'd2);
    idle(1'b1);
    chk("R7 cleared", {30'd0, sat_sticky}, 32'd0);

    // R6/R7: sum flag persists across later clean operations
    issue(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 1'b0);
    issue(32'h0000_0001, 32'h0000_0001, 1'b0, 1'b1, 1'b0);
    chk("R7 sticky persists", {30'd0, sat_sticky}, 32'd1);
    chk("R2 clean sum after sat", sum_q, 32'h0000_0002);

    // R10: wrapping overflow in dual mode raises no flag
    idle(1'b1);
    issue(32'h7FFF_7FFF, 32'h0001_0001, 1'b1, 1'b0, 1'b0);
    chk("R10 lane wrap sum", sum_q, 32'h8000_8000);
    chk("R10 no flag", {30'd0, sat_sticky}, 32'd0);

    // R5: only the high lane saturates on the difference path
    issue(32'h8000_0005, 32'h0001_0003, 1'b1, 1'b1, 1'b0);
    chk("R5 mixed lanes diff", diff_q, 32'h8000_0002);
    chk("R5 mixed lanes sum", sum_q, 32'h8001_0008);
    chk("R5 diff flag only", {30'd0, sat_sticky}, 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule